// File: doc/BRIEF.md
# DTMF Dual-Tone Sine Synthesizer

This block turns a 4-bit key code into a signed PCM stream that carries one row tone and one column tone added together. Each tone comes from its own 24-bit phase accumulator. The accumulator advances by a constant increment once per sample strobe. Its top bits address a quarter-wave sine table that both tones share. The table output is scaled by a per-tone amplitude, and the column tone is set about 1 dB louder than the row tone. The 3.579545 MHz reference clock, divided down to the sample strobe, fixes the sample rate. The increments are computed from that rate when the design is elaborated.

A controller drives the key code and an enable bit. A small state machine sequences the output. It has three states:

- **IDLE**: the output is held at mid-scale (zero).
- **ARM**: entered from IDLE on the *start* transition, which happens when enable is seen high. Both accumulators are cleared, the key code is captured, and the output stays at zero until the first strobe.
- **RUN**: entered from ARM on the *first-strobe* transition. On each strobe the block emits one sample and advances both phases.

The *stop* transition returns ARM or RUN to IDLE as soon as enable is seen low. While RUN is active, a new key code is adopted only when the row accumulator wraps. Both phases therefore stay continuous across a key change.

Top module: `dtmf_synth`

## Requirements
- R1: The key code selects a row/column pair. Codes 1..9 give the 3x3 grid in reading order. Code 10 is key 0 (row 941 Hz, column 1336 Hz). Code 11 is `*` (941/1209). Code 12 is `#` (941/1477). Codes 13, 14 and 15 are A, B and C on rows 697, 770 and 852 Hz with the 1633 Hz column. Code 0 is D (941/1633). The rows of keys 1-3, 4-6 and 7-9 are 697, 770 and 852 Hz. Their columns are 1209, 1336 and 1477 Hz.
- R2: Each tone's phase advances by round(f * 2^24 * STROBE_DIV / REF_HZ) per strobe, modulo 2^24. This keeps every tone within 1.5% of its nominal frequency. Phases do not move without a strobe.
- R3: The column tone peak is AMP_HI (1024 LSB). The row tone peak is AMP_HI * 0.891, which is 1 dB lower.
- R4: `sample_o` is two's complement. It equals AMP_row*sin(2*pi*phase_row/2^24) + AMP_col*sin(2*pi*phase_col/2^24), taken at the phase before the strobe, within 30 LSB. It updates at the clock edge that samples the strobe and holds between strobes.
- R5: |sample_o| never exceeds the sum of the two tone peaks.
- R6: If enable is low at a clock edge, `sample_o` is exactly 0 after that edge.
- R7: When enable is seen high in IDLE (start), both phases are cleared and `digit_i` is captured. The first emitted sample uses phase zero.
- R8: In RUN, a change of `digit_i` is ignored until a strobe wraps the row accumulator. At that edge the present `digit_i` is captured for the following strobes.
- R9: After reset the block is in IDLE and `sample_o` is 0.
- R10: In ARM, `sample_o` stays 0 until the first strobe, which moves the block to RUN. RUN never returns to ARM without passing through IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (3.579545 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_i | input | 4 | Key code, encoded as in R1 |
| enable_i | input | 1 | Tone on when high, mid-scale output when low |
| strobe_i | input | 1 | One-cycle sample strobe at REF_HZ/STROBE_DIV |
| sample_o | output | OUT_W (12) | Signed PCM sample, 0 is mid-scale |

## Verification
The bench drives all sixteen key codes and compares each output sample against a sine sum built from the nominal frequencies. A swapped row or column, or an increment off by more than the tolerance, makes the waveform drift away within a few hundred samples. It changes the key in the middle of a run at unaligned times. A design that switched immediately, instead of at a row wrap, would jump to the new frequency early and miss the reference. It holds enable high with no strobe to stay in ARM, drops enable inside ARM, and restarts with a single idle cycle. A design that failed to clear its phases on restart, or that leaked a nonzero value before the first strobe, would show a phase-shifted waveform or a stray sample there. Long runs on the highest and lowest tones expose small rounding errors in the increments and a wrong 1 dB weighting.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    // Row (low group) frequency in Hz for row index 0..3.
    function automatic longint unsigned row_hz(input int idx);
        case (idx)
            0:       return 64'd697;
            1:       return 64'd770;
            2:       return 64'd852;
            default: return 64'd941;
        endcase
    endfunction

    // Column (high group) frequency in Hz for column index 0..3.
    function automatic longint unsigned col_hz(input int idx);
        case (idx)
            0:       return 64'd1209;
            1:       return 64'd1336;
            2:       return 64'd1477;
            default: return 64'd1633;
        endcase
    endfunction

    // Rounded phase increment: hz * 2^acc_w / (ref_hz / div).
    function automatic longint unsigned phase_step(
        input longint unsigned hz,
        input int              acc_w,
        input longint unsigned ref_hz,
        input longint unsigned div
    );
        longint unsigned num;
        num = hz * (64'd1 << acc_w) * div * 64'd2 + ref_hz;
        return num / (64'd2 * ref_hz);
    endfunction

    // Quarter-wave sine sample at the centre of slot idx out of 2^aw,
    // scaled to peak. Fixed-point Taylor series in Q30.
    function automatic int quarter_sine(input int idx, input int aw, input int peak);
        longint one;
        longint x;
        longint term;
        longint acc;
        one  = 64'sd1 << 30;
        x    = (64'sd3373259426 * longint'(2 * idx + 1)) / (64'sd4 * (64'sd1 << aw));
        term = x;
        acc  = x;
        for (int k = 1; k <= 4; k++) begin
            term = -((((term * x) / one) * x) / one) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return int'((acc * longint'(peak) + (one >>> 1)) / one);
    endfunction

endpackage

// File: rtl/dtmf_key_decode.sv
// Key code to row/column index of the 4x4 keypad grid.
module dtmf_key_decode (
    input  logic [3:0] code_i,
    output logic [1:0] row_o,
    output logic [1:0] col_o
);

    always_comb begin
        unique case (code_i)
            4'd1:  begin row_o = 2'd0; col_o = 2'd0; end
            4'd2:  begin row_o = 2'd0; col_o = 2'd1; end
            4'd3:  begin row_o = 2'd0; col_o = 2'd2; end
            4'd13: begin row_o = 2'd0; col_o = 2'd3; end
            4'd4:  begin row_o = 2'd1; col_o = 2'd0; end
            4'd5:  begin row_o = 2'd1; col_o = 2'd1; end
            4'd6:  begin row_o = 2'd1; col_o = 2'd2; end
            4'd14: begin row_o = 2'd1; col_o = 2'd3; end
            4'd7:  begin row_o = 2'd2; col_o = 2'd0; end
            4'd8:  begin row_o = 2'd2; col_o = 2'd1; end
            4'd9:  begin row_o = 2'd2; col_o = 2'd2; end
            4'd15: begin row_o = 2'd2; col_o = 2'd3; end
            4'd11: begin row_o = 2'd3; col_o = 2'd0; end
            4'd10: begin row_o = 2'd3; col_o = 2'd1; end
            4'd12: begin row_o = 2'd3; col_o = 2'd2; end
            4'd0:  begin row_o = 2'd3; col_o = 2'd3; end
        endcase
    end

endmodule

// File: rtl/dtmf_phase_acc.sv
// Phase accumulator with synchronous clear and a wrap flag.
module dtmf_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] phase_o,
    output logic             wrap_o
);

    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_q;

    assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
    assign wrap_o  = step_i & sum[ACC_W];
    assign phase_o = acc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/dtmf_sine_tone.sv
// Quarter-wave table lookup with quadrant folding and amplitude scaling.
module dtmf_sine_tone #(
    parameter int LUT_AW = 6,
    parameter int SIN_W  = 12,
    parameter int OUT_W  = 12,
    parameter int AMP    = 1024
) (
    input  logic [LUT_AW+1:0]       phase_i,
    output logic signed [OUT_W-1:0] tone_o
);

    localparam int LUT_N = 1 << LUT_AW;
    localparam int PEAK  = (1 << SIN_W) - 1;
    localparam int AMP_W = $clog2(AMP + 1);
    localparam int PW    = SIN_W + AMP_W + 2;

    logic [SIN_W-1:0] rom [LUT_N];

    generate
        for (genvar g = 0; g < LUT_N; g++) begin : g_rom
            assign rom[g] = SIN_W'(dtmf_pkg::quarter_sine(g, LUT_AW, PEAK));
        end
    endgenerate

    logic              negate;
    logic              mirror;
    logic [LUT_AW-1:0] idx;
    logic [LUT_AW-1:0] addr;
    logic [SIN_W-1:0]  mag;
    logic signed [PW-1:0] sval;
    logic signed [PW-1:0] ampv;
    logic signed [PW-1:0] prod;

    assign negate = phase_i[LUT_AW+1];
    assign mirror = phase_i[LUT_AW];
    assign idx    = phase_i[LUT_AW-1:0];
    assign addr   = mirror ? ~idx : idx;
    assign mag    = rom[addr];
    assign sval   = negate ? -$signed(PW'(mag)) : $signed(PW'(mag));
    assign ampv   = PW'(AMP);
    assign prod   = sval * ampv;
    assign tone_o = OUT_W'(prod >>> SIN_W);

endmodule

// File: rtl/dtmf_synth.sv
// Dual-tone keypad synthesizer: two phase lanes, shared sine table form,
// three-state sequencer.
module dtmf_synth #(
    parameter int REF_HZ      = 3579545,
    parameter int STROBE_DIV  = 448,
    parameter int ACC_W       = 24,
    parameter int LUT_AW      = 6,
    parameter int SIN_W       = 12,
    parameter int OUT_W       = 12,
    parameter int AMP_HI      = 1024,
    parameter int LO_PERMILLE = 891
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [3:0]              digit_i,
    input  logic                    enable_i,
    input  logic                    strobe_i,
    output logic signed [OUT_W-1:0] sample_o
);

    import dtmf_pkg::*;

    localparam int AMP_LO = (AMP_HI * LO_PERMILLE + 500) / 1000;
    localparam int PH_W   = LUT_AW + 2;
    localparam int N_GRP  = 4;
    localparam int N_LANE = 2;

    // Increment tables, one entry per row and per column.
    logic [ACC_W-1:0] row_inc [N_GRP];
    logic [ACC_W-1:0] col_inc [N_GRP];

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_inc
            assign row_inc[g] = ACC_W'(phase_step(row_hz(g), ACC_W,
                                    longint'(REF_HZ), longint'(STROBE_DIV)));
            assign col_inc[g] = ACC_W'(phase_step(col_hz(g), ACC_W,
                                    longint'(REF_HZ), longint'(STROBE_DIV)));
        end
    endgenerate

    gen_state_e state_q, state_d;
    logic [3:0] code_q;
    logic [1:0] row_idx, col_idx;
    logic       start, step;
    logic signed [OUT_W-1:0] sample_q;

    logic [N_LANE-1:0][ACC_W-1:0] lane_inc;
    logic [N_LANE-1:0][ACC_W-1:0] phase;
    logic [N_LANE-1:0]            wrap;
    logic [N_LANE-1:0][OUT_W-1:0] tone;

    assign start = (state_q == ST_IDLE) && enable_i;
    assign step  = (state_q != ST_IDLE) && enable_i && strobe_i;

    dtmf_key_decode u_dec (
        .code_i (code_q),
        .row_o  (row_idx),
        .col_o  (col_idx)
    );

    assign lane_inc[0] = row_inc[row_idx];
    assign lane_inc[1] = col_inc[col_idx];

    // Lane 0 carries the row tone, lane 1 the louder column tone.
    generate
        for (genvar t = 0; t < N_LANE; t++) begin : g_lane
            localparam int LANE_AMP = (t == 0) ? AMP_LO : AMP_HI;
            logic signed [OUT_W-1:0] lane_tone;

            dtmf_phase_acc #(.ACC_W(ACC_W)) u_acc (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .clear_i (start),
                .step_i  (step),
                .inc_i   (lane_inc[t]),
                .phase_o (phase[t]),
                .wrap_o  (wrap[t])
            );

            dtmf_sine_tone #(
                .LUT_AW (LUT_AW),
                .SIN_W  (SIN_W),
                .OUT_W  (OUT_W),
                .AMP    (LANE_AMP)
            ) u_tone (
                .phase_i (phase[t][ACC_W-1 -: PH_W]),
                .tone_o  (lane_tone)
            );

            assign tone[t] = lane_tone;
        end
    endgenerate

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, first-strobe, stop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i) state_d = ST_ARM;
            ST_ARM: begin
                if (!enable_i)     state_d = ST_IDLE;
                else if (strobe_i) state_d = ST_RUN;
            end
            ST_RUN:  if (!enable_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: captured key code and PCM sample.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q   <= '0;
            sample_q <= '0;
        end else begin
            if (start || (step && wrap[0])) begin
                code_q <= digit_i;
            end
            if (step) begin
                sample_q <= $signed(tone[0]) + $signed(tone[1]);
            end else if (!enable_i || state_q == ST_IDLE) begin
                sample_q <= '0;
            end
        end
    end

    assign sample_o = sample_q;

endmodule

// File: rtl/dtmf_synth_chk.sv
// Temporal checks for dtmf_synth, attached by bind below.
module dtmf_synth_chk #(
    parameter int ACC_W   = 24,
    parameter int OUT_W   = 12,
    parameter int AMP_SUM = 1936
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         enable_i,
    input logic                         strobe_i,
    input dtmf_pkg::gen_state_e         state_q,
    input logic [3:0]                   code_q,
    input logic [1:0][ACC_W-1:0]        phase,
    input logic [1:0][ACC_W-1:0]        lane_inc,
    input logic [1:0]                   wrap,
    input logic signed [OUT_W-1:0]      sample_o
);

    import dtmf_pkg::*;

    logic in_idle, go, adv;
    assign in_idle = (state_q == ST_IDLE);
    assign go      = in_idle && enable_i;
    assign adv     = !in_idle && enable_i && strobe_i;

    // R6: disabled means mid-scale on the next cycle.
    a_r6_midscale_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> sample_o == '0);

    // R7: start clears both phases and lands in ARM.
    a_r7_start_clears_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go |=> (phase[0] == '0 && phase[1] == '0 && state_q == ST_ARM));

    // R8: captured code moves only at start or at a row wrap.
    a_r8_code_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!go && !(adv && wrap[0])) |=> $stable(code_q));

    // R2: phases move only on a strobe.
    a_r2_phase_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!go && !adv) |=> ($stable(phase[0]) && $stable(phase[1])));

    // R2: after a wrap the phase is below one increment.
    a_r2_row_wrap_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap[0] |=> phase[0] < $past(lane_inc[0]));
    a_r2_col_wrap_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap[1] |=> phase[1] < $past(lane_inc[1]));

    // R4: output holds between strobes while running.
    a_r4_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && enable_i && !strobe_i) |=> $stable(sample_o));

    // R5: no overflow beyond the summed peaks.
    a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($signed(sample_o) <= AMP_SUM && $signed(sample_o) >= -AMP_SUM));

    // R10: ARM keeps the output quiet and RUN never goes back to ARM.
    a_r10_arm_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_ARM |-> sample_o == '0);
    a_r10_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_RUN |=> state_q != ST_ARM);

endmodule

bind dtmf_synth dtmf_synth_chk #(
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .AMP_SUM (AMP_LO + AMP_HI)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .strobe_i (strobe_i),
    .state_q  (state_q),
    .code_q   (code_q),
    .phase    (phase),
    .lane_inc (lane_inc),
    .wrap     (wrap),
    .sample_o (sample_o)
);

// File: tb/sim_dtmf_synth.sv
module sim_dtmf_synth;
    timeunit 1ns;
    timeprecision 1ps;

    localparam real REF     = 3579545.0;
    localparam real DIV     = 448.0;
    localparam real TWO24   = 16777216.0;
    localparam real AMP_C   = 1024.0;
    localparam real AMP_R   = 1024.0 * 0.8913;
    localparam real TOL     = 30.0;
    localparam int  PEAKSUM = 1937;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit = 4'd0;
    logic       en = 1'b0;
    logic       strobe = 1'b0;
    logic       strobe_on = 1'b1;
    logic signed [11:0] sample;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R9";

    dtmf_synth u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .digit_i  (digit),
        .enable_i (en),
        .strobe_i (strobe),
        .sample_o (sample)
    );

    always #2 clk = ~clk;   // 250 MHz

    // ---------------- behavioural reference model ----------------
    int row_f [4] = '{697, 770, 852, 941};
    int col_f [4] = '{1209, 1336, 1477, 1633};

    function automatic longint incr(input int hz);
        return longint'($floor(real'(hz) * TWO24 * DIV / REF + 0.5));
    endfunction

    function automatic void key_rc(input int c, output int r, output int k);
        case (c)
            1: begin r = 0; k = 0; end   2: begin r = 0; k = 1; end
            3: begin r = 0; k = 2; end   13: begin r = 0; k = 3; end
            4: begin r = 1; k = 0; end   5: begin r = 1; k = 1; end
            6: begin r = 1; k = 2; end   14: begin r = 1; k = 3; end
            7: begin r = 2; k = 0; end   8: begin r = 2; k = 1; end
            9: begin r = 2; k = 2; end   15: begin r = 2; k = 3; end
            11: begin r = 3; k = 0; end  10: begin r = 3; k = 1; end
            12: begin r = 3; k = 2; end  default: begin r = 3; k = 3; end
        endcase
    endfunction

    int     m_state = 0;          // 0 idle, 1 armed, 2 running
    longint m_row = 0, m_col = 0;
    int     m_code = 0;
    real    m_exp = 0.0;
    bit     m_exact = 1'b1;

    task automatic model_emit();
        int r, k;
        longint nr;
        m_exp = AMP_R * $sin(2.0 * 3.14159265358979 * real'(m_row) / TWO24)
              + AMP_C * $sin(2.0 * 3.14159265358979 * real'(m_col) / TWO24);
        m_exact = 1'b0;
        key_rc(m_code, r, k);
        nr    = m_row + incr(row_f[r]);
        m_col = (m_col + incr(col_f[k])) % 64'd16777216;
        m_row = nr % 64'd16777216;
        if (nr >= 64'd16777216) m_code = int'(digit);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_exp = 0.0; m_exact = 1'b1;
        end else begin
            case (m_state)
                0: begin
                    m_exp = 0.0; m_exact = 1'b1;
                    if (en) begin
                        m_row = 0; m_col = 0; m_code = int'(digit); m_state = 1;
                    end
                end
                1: begin
                    if (!en) begin m_state = 0; m_exp = 0.0; m_exact = 1'b1; end
                    else if (strobe) begin model_emit(); m_state = 2; end
                end
                default: begin
                    if (!en) begin m_state = 0; m_exp = 0.0; m_exact = 1'b1; end
                    else if (strobe) model_emit();
                end
            endcase
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (m_exact) begin
                if (sample !== 12'sd0) begin
                    fails++;
                    $display("FAIL %s: sample=%0d expected=0",
                             (m_state == 1) ? "R10" : "R6", sample);
                end
            end else if ((real'(sample) - m_exp > TOL) || (m_exp - real'(sample) > TOL)) begin
                fails++;
                $display("FAIL %s/R4: sample=%0d expected=%0.1f", tag, sample, m_exp);
            end
            checks++;
            if (sample > PEAKSUM || sample < -PEAKSUM) begin
                fails++;
                $display("FAIL R5: sample=%0d expected |x|<=%0d", sample, PEAKSUM);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic play(input int code, input int n);
        digit = 4'(code);
        en = 1'b1;
        wait_cyc(n);
        en = 1'b0;
        wait_cyc(4);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #600000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected end before timeout");
        finish_run();
    end

    initial begin
        fork
            forever begin
                @(negedge clk);
                strobe = strobe_on && !strobe;
            end
        join_none

        // R9: reset state
        wait_cyc(5);
        checks++;
        if (sample !== 12'sd0) begin
            fails++;
            $display("FAIL R9: sample=%0d expected=0", sample);
        end
        rst_n = 1'b1;
        wait_cyc(3);

        // R1: every key code
        tag = "R1";
        for (int c = 0; c < 16; c++) play(c, 200);

        // R3: amplitude weighting over a longer run
        tag = "R3";
        play(5, 2000);

        // R10: hold in ARM without strobes, drop enable in ARM, then run
        tag = "R10";
        strobe_on = 1'b0;
        digit = 4'd3;
        en = 1'b1;
        wait_cyc(10);
        en = 1'b0;
        wait_cyc(3);
        en = 1'b1;
        wait_cyc(6);
        strobe_on = 1'b1;
        wait_cyc(400);
        en = 1'b0;
        wait_cyc(4);

        // R8: key changes mid-run take effect only at a row wrap
        tag = "R8";
        digit = 4'd1;
        en = 1'b1;
        wait_cyc(101);
        digit = 4'd9;
        wait_cyc(300);
        digit = 4'd12;
        wait_cyc(57);
        digit = 4'd0;
        wait_cyc(500);
        en = 1'b0;
        wait_cyc(4);

        // R7: restart after a single idle cycle clears phase
        tag = "R7";
        digit = 4'd7;
        en = 1'b1;
        wait_cyc(300);
        en = 1'b0;
        wait_cyc(1);
        digit = 4'd2;
        en = 1'b1;
        wait_cyc(300);
        en = 1'b0;
        wait_cyc(4);

        // R2: long runs on the extreme tones
        tag = "R2";
        play(13, 20000);
        play(0, 20000);
        play(1, 20000);

        finish_run();
    end

endmodule